// File: doc/BRIEF.md
# Local Interrupt Arbitration for a Privileged Hart

This block decides which local interrupt a hart takes next. It forms the set of requests that are both raised and unmasked. It then applies the global enable of the level that will handle each request and returns the lowest-numbered survivor. Each request is routed either to the machine level or, when its delegation bit is set, to the supervisor level. A request routed to a level above the hart's current privilege is always allowed. A request routed to the hart's current level is allowed only when that level's global enable is set. A request routed to a level below the current privilege is never allowed.

When the hypervisor option is built in and the hart runs virtualized, the three guest-supervisor lines (software 2, timer 6, external 10) are set apart. The remaining requests are checked first against the host-supervisor enable. If any of them survives, it wins and a force-to-host flag is raised. Only when none survives are the guest lines arbitrated through the ordinary delegation path.

The result is a valid flag, a 6-bit interrupt number and the force flag. By default these outputs are registered once. A trap sequencer samples them to start interrupt entry.

Top module: `irq_pending_select`

## Requirements
- R1: A line can be selected only when its bit is set in both `irq_pend` and `irq_en`.
- R2: A line whose `irq_deleg` bit is 0 is allowed when `priv` is U (0) or S (1), or when `priv` is M (3) and `st_mie` is 1.
- R3: A line whose `irq_deleg` bit is 1 is allowed when `priv` is U, or when `priv` is S and `st_sie` is 1. It is never allowed when `priv` is M.
- R4: Among allowed lines, the lowest-numbered one is reported on `irq_id`, and `irq_valid` is 1.
- R5: When no line is allowed, `irq_valid`, `irq_id` and `force_hs` are all 0.
- R6: A `priv` value of 2 behaves exactly like U.
- R7: With `virt_on` = 1, lines other than 2, 6 and 10 are gated only by the host enable. That enable is open when `priv` is U or 2, or when `priv` is S and `hs_sie` is 1. Any such line wins over every guest line, even a lower-numbered one, and drives `force_hs` to 1.
- R8: With `virt_on` = 1 and no line winning under R7, only lines 2, 6 and 10 compete, using the rules of R2 and R3, and `force_hs` is 0. Other lines are not selected on this path.
- R9: With `virt_on` = 0, `force_hs` is 0, and lines 2, 6 and 10 compete like any other line.
- R10: The outputs reflect the inputs one clock after they are applied. While `rst_n` is 0 at a rising clock edge, all outputs are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend | input | 64 | Raised interrupt lines |
| irq_en | input | 64 | Per-line unmask bits |
| irq_deleg | input | 64 | Per-line routing to supervisor level |
| priv | input | 2 | Current privilege: U=0, S=1, M=3, 2 acts as U |
| st_mie | input | 1 | Machine global enable |
| st_sie | input | 1 | Supervisor global enable |
| virt_on | input | 1 | Hart is running virtualized |
| hs_sie | input | 1 | Host-supervisor global enable |
| irq_valid | output | 1 | A line has been selected |
| irq_id | output | 6 | Number of the selected line |
| force_hs | output | 1 | Selection must be handled by the host supervisor |

## Verification
Single-line patterns test each gating rule in turn: raised but masked, non-delegated at each privilege with the machine enable on and off, and delegated at each privilege with the supervisor enable on and off. Privilege 2 is compared against U. Multi-line patterns test priority. Lines 3, 7 and 11 together test lowest-first selection. A delegated low line blocked in M mode alongside an open higher line shows that gating happens before the priority search. With virtualization on, a guest line below a host line checks that the host group takes precedence. A host line with the host enable closed checks that it does not leak into the guest path. The same vector with virtualization off shows the guest lines rejoining the normal order. A reset applied while requests are active shows the outputs clearing.

// File: rtl/irq_sel_pkg.sv
`timescale 1ns/1ps
// Package: shared privilege encoding and the guest-supervisor line group.
// Assumes at most MAX_LINES interrupt lines.
package irq_sel_pkg;
    localparam int MAX_LINES = 64;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPV  = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } lvl_e;

    // Guest software, timer and external lines.
    localparam logic [MAX_LINES-1:0] GUEST_GROUP =
        (64'd1 << 2) | (64'd1 << 6) | (64'd1 << 10);
endpackage

// File: rtl/irq_level_gate.sv
`timescale 1ns/1ps
// Module: irq_level_gate
// Turns the current privilege and global enable bits into one "allowed"
// flag per handling level. Assumes the reserved privilege code acts as user.
module irq_level_gate
    import irq_sel_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       st_mie,
    input  logic       st_sie,
    input  logic       hs_sie,
    output logic       mach_ok,
    output logic       supv_ok,
    output logic       host_ok
);
    lvl_e lvl;

    // Fold the reserved code onto user level.
    always_comb begin
        lvl = lvl_e'(priv);
        if (lvl == LVL_RSVD) lvl = LVL_USER;
    end

    // Higher target level is always open; equal level needs its enable.
    always_comb begin
        unique case (lvl)
            LVL_MACH: begin
                mach_ok = st_mie;
                supv_ok = 1'b0;
                host_ok = 1'b0;
            end
            LVL_SUPV: begin
                mach_ok = 1'b1;
                supv_ok = st_sie;
                host_ok = hs_sie;
            end
            default: begin
                mach_ok = 1'b1;
                supv_ok = 1'b1;
                host_ok = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/irq_first_set.sv
`timescale 1ns/1ps
// Module: irq_first_set
// Finds the lowest set bit of a vector (trailing-zero count).
// Assumes IDX_W is wide enough to hold LINES-1.
module irq_first_set #(
    parameter int LINES = 64,
    parameter int IDX_W = 6
) (
    input  logic [LINES-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_pending_select.sv
`timescale 1ns/1ps
// Module: irq_pending_select
// Chooses the next local interrupt from raised, unmasked and routed lines.
// With HYP_EN, host lines are arbitrated before the guest group while
// virtualized. With OUT_REG, results appear one clock later.
// Assumes LINES <= 64.
module irq_pending_select
    import irq_sel_pkg::*;
#(
    parameter int LINES   = 64,
    parameter bit HYP_EN  = 1'b1,
    parameter bit OUT_REG = 1'b1,
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_pend,
    input  logic [LINES-1:0] irq_en,
    input  logic [LINES-1:0] irq_deleg,
    input  logic [1:0]       priv,
    input  logic             st_mie,
    input  logic             st_sie,
    input  logic             virt_on,
    input  logic             hs_sie,
    output logic             irq_valid,
    output logic [IDX_W-1:0] irq_id,
    output logic             force_hs
);
    localparam logic [LINES-1:0] GUEST = GUEST_GROUP[LINES-1:0];

    logic             mach_ok, supv_ok, host_ok, virt_eff;
    logic [LINES-1:0] active, host_cand, route_src, route_cand;
    logic             host_hit, route_hit;
    logic [IDX_W-1:0] host_idx, route_idx;
    logic             nxt_valid, nxt_force;
    logic [IDX_W-1:0] nxt_id;

    irq_level_gate u_gate (
        .priv    (priv),
        .st_mie  (st_mie),
        .st_sie  (st_sie),
        .hs_sie  (hs_sie),
        .mach_ok (mach_ok),
        .supv_ok (supv_ok),
        .host_ok (host_ok)
    );

    // Raised and unmasked lines; virtualization only counts when built in.
    always_comb begin
        active   = irq_pend & irq_en;
        virt_eff = HYP_EN & virt_on;
    end

    // Host-first candidates and routed candidates for the normal path.
    always_comb begin
        host_cand  = virt_eff ? (active & ~GUEST & {LINES{host_ok}}) : '0;
        route_src  = virt_eff ? (active & GUEST) : active;
        route_cand = (route_src & ~irq_deleg & {LINES{mach_ok}})
                   | (route_src &  irq_deleg & {LINES{supv_ok}});
    end

    irq_first_set #(.LINES(LINES), .IDX_W(IDX_W)) u_host_pick (
        .vec   (host_cand),
        .found (host_hit),
        .idx   (host_idx)
    );

    irq_first_set #(.LINES(LINES), .IDX_W(IDX_W)) u_route_pick (
        .vec   (route_cand),
        .found (route_hit),
        .idx   (route_idx)
    );

    // Host winner takes precedence; otherwise the routed winner.
    always_comb begin
        nxt_valid = host_hit | route_hit;
        nxt_force = host_hit;
        nxt_id    = host_hit ? host_idx : (route_hit ? route_idx : '0);
    end

    generate
        if (OUT_REG) begin : g_reg
            // Output register with synchronous clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    irq_valid <= 1'b0;
                    irq_id    <= '0;
                    force_hs  <= 1'b0;
                end else begin
                    irq_valid <= nxt_valid;
                    irq_id    <= nxt_id;
                    force_hs  <= nxt_force;
                end
            end
        end else begin : g_comb
            // Pass-through when no output stage is wanted.
            always_comb begin
                irq_valid = nxt_valid;
                irq_id    = nxt_id;
                force_hs  = nxt_force;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_sel_chk.sv
`timescale 1ns/1ps
// Module: irq_sel_chk
// Property checker bound to irq_pending_select. It keeps its own delayed
// copy of the inputs so that outputs are judged against the inputs that
// produced them.
module irq_sel_chk #(
    parameter int LINES   = 64,
    parameter bit HYP_EN  = 1'b1,
    parameter bit OUT_REG = 1'b1,
    parameter int IDX_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] irq_pend,
    input logic [LINES-1:0] irq_en,
    input logic [LINES-1:0] irq_deleg,
    input logic [1:0]       priv,
    input logic             st_mie,
    input logic             virt_on,
    input logic             irq_valid,
    input logic [IDX_W-1:0] irq_id,
    input logic             force_hs
);
    logic [LINES-1:0] act_s, deleg_s;
    logic [1:0]       priv_s;
    logic             mie_s, virt_s;

    generate
        if (OUT_REG) begin : g_dly
            // Align inputs with the registered outputs.
            always_ff @(posedge clk) begin
                act_s   <= irq_pend & irq_en;
                deleg_s <= irq_deleg;
                priv_s  <= priv;
                mie_s   <= st_mie;
                virt_s  <= HYP_EN & virt_on;
            end
        end else begin : g_now
            // Outputs follow inputs directly.
            always_comb begin
                act_s   = irq_pend & irq_en;
                deleg_s = irq_deleg;
                priv_s  = priv;
                mie_s   = st_mie;
                virt_s  = HYP_EN & virt_on;
            end
        end
    endgenerate

    AST_PICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> act_s[irq_id]); // R1
    AST_M_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_s == 2'd3 && !mie_s && !virt_s) |-> !irq_valid); // R2
    AST_M_NO_DELEG: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_s == 2'd3 && !virt_s && irq_valid) |-> !deleg_s[irq_id]); // R3
    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_id == '0 && !force_hs)); // R5
    AST_FORCE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        force_hs |-> irq_valid); // R7
    AST_FORCE_NOT_GUEST: assert property (@(posedge clk) disable iff (!rst_n)
        force_hs |-> (irq_id != 6'd2 && irq_id != 6'd6 && irq_id != 6'd10)); // R7
    AST_NOVIRT_NO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        !virt_s |-> !force_hs); // R9
endmodule

bind irq_pending_select irq_sel_chk #(
    .LINES(LINES), .HYP_EN(HYP_EN), .OUT_REG(OUT_REG), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_deleg(irq_deleg), .priv(priv), .st_mie(st_mie), .virt_on(virt_on),
    .irq_valid(irq_valid), .irq_id(irq_id), .force_hs(force_hs)
);

// File: tb/sim_irq_pending_select.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them one clock after each stimulus.
module sim_irq_pending_select;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pend = '0, en = '0, dlg = '0;
    logic [1:0]  priv = 2'd0;
    logic        mie = 1'b0, sie = 1'b0, virt = 1'b0, hsie = 1'b0;
    logic        o_valid, o_force;
    logic [5:0]  o_id;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic       v;
        logic [5:0] id;
        logic       f;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    irq_pending_select u0 (
        .clk(clk), .rst_n(rst_n), .irq_pend(pend), .irq_en(en),
        .irq_deleg(dlg), .priv(priv), .st_mie(mie), .st_sie(sie),
        .virt_on(virt), .hs_sie(hsie), .irq_valid(o_valid), .irq_id(o_id),
        .force_hs(o_force)
    );

    // Independent model written from the requirements.
    function automatic exp_t model(input logic [63:0] p, e, d,
                                   input logic [1:0] pv,
                                   input logic m, s, vt, hs, input string t);
        exp_t r;
        int lv;
        bit m_open, s_open, h_open, guest;
        r.v = 0; r.id = 0; r.f = 0; r.tag = t;
        lv = (pv == 2) ? 0 : int'(pv);
        m_open = (lv != 3) || m;
        s_open = (lv == 0) || (lv == 1 && s);
        h_open = (lv == 0) || (lv == 1 && hs);
        if (vt) begin
            for (int i = 0; i < 64; i++) begin
                guest = (i == 2 || i == 6 || i == 10);
                if (p[i] && e[i] && !guest && h_open) begin
                    r.v = 1; r.id = 6'(i); r.f = 1; return r;
                end
            end
        end
        for (int i = 0; i < 64; i++) begin
            guest = (i == 2 || i == 6 || i == 10);
            if (p[i] && e[i] && (!vt || guest) && (d[i] ? s_open : m_open)) begin
                r.v = 1; r.id = 6'(i); return r;
            end
        end
        return r;
    endfunction

    task automatic drive(input logic [63:0] p, e, d, input logic [1:0] pv,
                         input logic m, s, vt, hs, input string t);
        @(negedge clk);
        pend = p; en = e; dlg = d; priv = pv;
        mie = m; sie = s; virt = vt; hsie = hs;
        sb.push_back(model(p, e, d, pv, m, s, vt, hs, t));
    endtask

    task automatic cmp(input exp_t x);
        checks++;
        if (o_valid !== x.v || o_id !== x.id || o_force !== x.f) begin
            errors++;
            $display("FAIL %s: got valid=%0b id=%0d force=%0b, expected valid=%0b id=%0d force=%0b",
                     x.tag, o_valid, o_id, o_force, x.v, x.id, x.f);
        end
    endtask

    // Monitor: results land at the edge after the stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) cmp(sb.pop_front());
        end
    end

    initial begin
        exp_t z;
        z.v = 0; z.id = 0; z.f = 0;
        // R10: reset state
        repeat (3) @(posedge clk);
        #5; z.tag = "R10 reset"; cmp(z);
        @(negedge clk); rst_n = 1'b1;

        drive(0, 0, 0, 0, 0, 0, 0, 0, "R5 nothing raised");
        drive(64'h20, 0, 0, 3, 1, 0, 0, 0, "R1 raised but masked");
        drive(64'h20, 64'h20, 0, 3, 1, 0, 0, 0, "R1 raised and unmasked");
        drive(64'h888, 64'h888, 0, 0, 0, 0, 0, 0, "R4 lowest of 3,7,11");
        drive(64'h80, 64'h80, 0, 3, 0, 0, 0, 0, "R2 M mode mie off");
        drive(64'h80, 64'h80, 0, 1, 0, 0, 0, 0, "R2 S mode opens machine");
        drive(64'h20, 64'h20, 64'h20, 1, 1, 0, 0, 0, "R3 S mode sie off");
        drive(64'h20, 64'h20, 64'h20, 1, 0, 1, 0, 0, "R3 S mode sie on");
        drive(64'h20, 64'h20, 64'h20, 0, 0, 0, 0, 0, "R3 U mode opens supervisor");
        drive(64'h20, 64'h20, 64'h20, 3, 1, 1, 0, 0, "R3 M mode blocks delegated");
        drive(64'h202, 64'h202, 64'h2, 3, 1, 1, 0, 0, "R3 R4 gating before priority");
        drive(64'h20, 64'h20, 64'h20, 2, 0, 0, 0, 0, "R6 code 2 as user deleg");
        drive(64'h80, 64'h80, 0, 2, 0, 0, 0, 0, "R6 code 2 as user mach");
        drive(64'h204, 64'h204, 0, 1, 0, 0, 1, 1, "R7 host before lower guest");
        drive(64'h2000, 64'h2000, 0, 0, 0, 0, 1, 0, "R7 user opens host");
        drive(64'h204, 64'h204, 64'h4, 1, 0, 1, 1, 0, "R8 guest path after host closed");
        drive(64'h200, 64'h200, 0, 1, 1, 1, 1, 0, "R8 host line not on guest path");
        drive(64'h440, 64'h440, 64'h440, 1, 0, 0, 1, 0, "R8 guest sie off");
        drive(64'h204, 64'h204, 0, 0, 0, 0, 0, 0, "R9 virt off guest lines normal");
        drive(64'h1 << 63, 64'h1 << 63, 0, 0, 0, 0, 0, 0, "R4 top line 63");
        drive(64'hFFFF_0000_0000_0000, 64'h00F0_0000_0000_0000, 0, 0, 0, 0, 0, 0, "R1 R4 partial mask");
        for (int k = 0; k < 4; k++) begin
            drive(64'h1 << (k * 5 + 1), 64'hFFFF_FFFF, 64'h0, 1, 0, 0, 0, 0, "R4 sweep");
        end
        @(negedge clk);
        @(negedge clk);
        // R10: reset with active requests clears outputs at the edge
        pend = 64'h8; en = 64'h8; priv = 0; rst_n = 1'b0;
        @(posedge clk); #5;
        z.tag = "R10 reset while active"; cmp(z);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #5;
        z.v = 1; z.id = 3; z.f = 0; z.tag = "R10 resume after reset"; cmp(z);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule